// File: doc/BRIEF.md
# Reversible-Gate Arithmetic Unit

A combinational arithmetic unit of parameterised width (default 4 bits) whose datapath is built only from three-in/three-out reversible primitives. Each bit slice has a Fredkin-style controlled-swap gate that conditions operand B into an addend Y. Each slice also has a full adder made of two Peres gates. The full adders form a ripple carry chain.

Two select lines and the carry input choose one of eight operations on A. All of them are A + Y + carry-in, where Y is zero, the inverse of B, B itself, or all ones. Because the gates are reversible, every gate output that the function does not use leaves the block as a garbage port. The zero constant that each adder consumes enters through an input port.

The unit drops into a datapath wherever a small add/subtract/increment/decrement stage is needed. It is also used to study the cost of reversibility, because its constant and garbage lines are exposed.

Top module: `rev_arith_unit`

## Requirements
- R1: The Peres gate maps (x, y, z) to (x, x^y, (x&y)^z), and its 8 input patterns give 8 distinct output patterns.
- R2: The controlled-swap gate maps (c, p, q) to (c, (~c&p)|(c&q), (c&p)|(~c&q)). Its 8 input patterns give 8 distinct output patterns, and the number of ones at the output always equals the number of ones at the input.
- R3: The per-bit addend Y depends on the select {s1_i,s0_i} as follows: 2'b00 gives 0, 2'b01 gives ~B, 2'b10 gives B, and 2'b11 gives 1. The bench observes Y as fa_garb_o[2i+1]^a_i[i].
- R4: When select is 2'b10, the result {cout_o,f_o} is A+B if cin_i=0 and A+B+1 if cin_i=1.
- R5: When select is 2'b01, the result is A+~B if cin_i=0 and A-B (twos complement) if cin_i=1.
- R6: When select is 2'b00, the result is A if cin_i=0 and A+1 if cin_i=1.
- R7: When select is 2'b11, the result is A-1 if cin_i=0 and A if cin_i=1.
- R8: cout_o is bit WIDTH of the (WIDTH+1)-bit sum A+Y+cin_i, and f_o holds its low WIDTH bits.
- R9: The garbage ports are laid out per bit i as follows:
  - fa_garb_o[2i]=a_i[i]
  - fa_garb_o[2i+1]=a_i[i]^Y[i]
  - cond_garb_o[2i]=b_i[i]
  - cond_garb_o[2i+1]=(b_i[i]&s0_i)|(~b_i[i]&s1_i)
- R10: The block has one constant input per bit, const_i, which must be tied to zero, and 4*WIDTH garbage outputs. For the default width that is 4 constants and 16 garbage lines.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | WIDTH | Operand A |
| b_i | input | WIDTH | Operand B, conditioned into Y |
| s0_i | input | 1 | Select, low bit |
| s1_i | input | 1 | Select, high bit |
| cin_i | input | 1 | Carry into bit 0 |
| const_i | input | WIDTH | Constant ancilla per adder, tie to 0 |
| f_o | output | WIDTH | Result |
| cout_o | output | 1 | Carry out of the top bit |
| fa_garb_o | output | 2*WIDTH | Adder garbage lines |
| cond_garb_o | output | 2*WIDTH | Conditioner garbage lines |

## Verification
The assertions assume that every bit of const_i is zero. With any other value, the first Peres gate of a slice feeds a flipped carry term into the second gate, and the arithmetic no longer holds. For that reason, every arithmetic assertion is gated off while const_i is non-zero. The bench drives const_i to zero throughout, so all sweeps and directed vectors stay inside that assumption. The two gate primitives are exercised on their own for their bijection and weight properties, independent of that tie-off.

// File: rtl/rev_pkg.sv
package rev_pkg;
  typedef enum logic [1:0] {
    SEL_ZERO = 2'b00,
    SEL_INV  = 2'b01,
    SEL_TRUE = 2'b10,
    SEL_ONES = 2'b11
  } cond_sel_e;

  localparam int unsigned GARB_PER_BIT  = 4;
  localparam int unsigned CONST_PER_BIT = 1;
endpackage

// File: rtl/peres_gate.sv
module peres_gate (
  input  logic x_i,
  input  logic y_i,
  input  logic z_i,
  output logic p_o,
  output logic q_o,
  output logic r_o
);
  assign p_o = x_i;
  assign q_o = x_i ^ y_i;
  assign r_o = (x_i & y_i) ^ z_i;
endmodule

// File: rtl/fredkin_gate.sv
module fredkin_gate (
  input  logic c_i,
  input  logic p_i,
  input  logic q_i,
  output logic c_o,
  output logic p_o,
  output logic q_o
);
  assign c_o = c_i;
  assign p_o = (~c_i & p_i) | (c_i & q_i);
  assign q_o = (c_i & p_i) | (~c_i & q_i);
endmodule

// File: rtl/rev_bit_slice.sv
module rev_bit_slice (
  input  logic       a_i,
  input  logic       b_i,
  input  logic       s0_i,
  input  logic       s1_i,
  input  logic       cin_i,
  input  logic       const_i,
  output logic       sum_o,
  output logic       cout_o,
  output logic [1:0] fa_garb_o,
  output logic [1:0] cond_garb_o
);
  logic y, ax, g0, axy, g1;

  // B steers which select line reaches Y: 0 -> s0, 1 -> s1
  fredkin_gate u_cond (
    .c_i (b_i),
    .p_i (s0_i),
    .q_i (s1_i),
    .c_o (cond_garb_o[0]),
    .p_o (y),
    .q_o (cond_garb_o[1])
  );

  peres_gate u_pg0 (
    .x_i (a_i),
    .y_i (y),
    .z_i (const_i),
    .p_o (g0),
    .q_o (ax),
    .r_o (axy)
  );

  peres_gate u_pg1 (
    .x_i (ax),
    .y_i (cin_i),
    .z_i (axy),
    .p_o (g1),
    .q_o (sum_o),
    .r_o (cout_o)
  );

  assign fa_garb_o = {g1, g0};
endmodule

// File: rtl/rev_arith_unit.sv
module rev_arith_unit #(
  parameter int unsigned WIDTH = 4
) (
  input  logic [WIDTH-1:0]   a_i,
  input  logic [WIDTH-1:0]   b_i,
  input  logic               s0_i,
  input  logic               s1_i,
  input  logic               cin_i,
  input  logic [WIDTH-1:0]   const_i,
  output logic [WIDTH-1:0]   f_o,
  output logic               cout_o,
  output logic [2*WIDTH-1:0] fa_garb_o,
  output logic [2*WIDTH-1:0] cond_garb_o
);
  localparam int unsigned GW = 2 * WIDTH;

  logic [WIDTH:0] carry;

  assign carry[0] = cin_i;

  for (genvar i = 0; i < WIDTH; i++) begin : g_slice
    rev_bit_slice u_slice (
      .a_i         (a_i[i]),
      .b_i         (b_i[i]),
      .s0_i        (s0_i),
      .s1_i        (s1_i),
      .cin_i       (carry[i]),
      .const_i     (const_i[i]),
      .sum_o       (f_o[i]),
      .cout_o      (carry[i+1]),
      .fa_garb_o   (fa_garb_o[2*i+1:2*i]),
      .cond_garb_o (cond_garb_o[2*i+1:2*i])
    );
  end

  assign cout_o = carry[WIDTH];

  if (GW != WIDTH * 2) begin : g_bad_width
    $error("garbage width mismatch");
  end
endmodule

// File: rtl/rev_arith_unit_chk.sv
module rev_arith_unit_chk #(
  parameter int unsigned WIDTH = 4
) (
  input logic [WIDTH-1:0]   a_i,
  input logic [WIDTH-1:0]   b_i,
  input logic               s0_i,
  input logic               s1_i,
  input logic               cin_i,
  input logic [WIDTH-1:0]   const_i,
  input logic [WIDTH-1:0]   f_o,
  input logic               cout_o,
  input logic [2*WIDTH-1:0] fa_garb_o,
  input logic [2*WIDTH-1:0] cond_garb_o
);
  import rev_pkg::*;

  logic [WIDTH-1:0] y_obs;
  logic [WIDTH:0]   total;
  logic             tied;

  always_comb begin
    tied = (const_i == '0);
    for (int i = 0; i < WIDTH; i++) y_obs[i] = fa_garb_o[2*i+1] ^ a_i[i];
    total = {1'b0, a_i} + {1'b0, y_obs} + {{WIDTH{1'b0}}, cin_i};
  end

  always_comb begin
    for (int i = 0; i < WIDTH; i++) begin
      // R9 pass-through lines
      a_r9_a_garb: assert (fa_garb_o[2*i] == a_i[i]);
      a_r9_b_garb: assert (cond_garb_o[2*i] == b_i[i]);
      // R2 weight conservation of each conditioner gate
      a_r2_weight: assert ($countones({b_i[i], s0_i, s1_i}) ==
                           $countones({cond_garb_o[2*i], y_obs[i], cond_garb_o[2*i+1]}));
    end
  end

  always_comb begin
    if (tied) begin
      // R3 addend per select
      case (cond_sel_e'({s1_i, s0_i}))
        SEL_ZERO: a_r3_y_zero: assert (y_obs == '0);
        SEL_INV:  a_r3_y_inv:  assert (y_obs == ~b_i);
        SEL_TRUE: a_r3_y_true: assert (y_obs == b_i);
        default:  a_r3_y_ones: assert (y_obs == '1);
      endcase
      // R8 result equals A+Y+cin
      a_r8_sum: assert ({cout_o, f_o} == total);
      // R1 bit 0 sum parity via adder garbage
      a_r1_lsb: assert (f_o[0] == (fa_garb_o[1] ^ cin_i));
    end
  end
endmodule

bind rev_arith_unit rev_arith_unit_chk #(.WIDTH(WIDTH)) u_chk (
  .a_i         (a_i),
  .b_i         (b_i),
  .s0_i        (s0_i),
  .s1_i        (s1_i),
  .cin_i       (cin_i),
  .const_i     (const_i),
  .f_o         (f_o),
  .cout_o      (cout_o),
  .fa_garb_o   (fa_garb_o),
  .cond_garb_o (cond_garb_o)
);

// File: tb/rev_arith_unit_tb.sv
module rev_arith_unit_tb;
  localparam int unsigned W = 4;
  localparam int unsigned NV = 12;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic [W-1:0]   a, b, cst;
  logic           s0, s1, cin;
  logic [W-1:0]   f;
  logic           cout;
  logic [2*W-1:0] fag, cdg;

  int total = 0;
  int bad   = 0;

  rev_arith_unit #(.WIDTH(W)) u_dut (
    .a_i(a), .b_i(b), .s0_i(s0), .s1_i(s1), .cin_i(cin), .const_i(cst),
    .f_o(f), .cout_o(cout), .fa_garb_o(fag), .cond_garb_o(cdg)
  );

  logic px, py, pz, pp, pq, pr;
  peres_gate u_pg (.x_i(px), .y_i(py), .z_i(pz), .p_o(pp), .q_o(pq), .r_o(pr));
  logic fc, fp, fq, oc, op, oq;
  fredkin_gate u_fg (.c_i(fc), .p_i(fp), .q_i(fq), .c_o(oc), .p_o(op), .q_o(oq));

  // {s1,s0}, cin, a, b, expected {cout,f}
  localparam logic [15:0] VEC [NV] = '{
    {2'b10, 1'b0, 4'h3, 4'h5, 5'd8},   // R4
    {2'b10, 1'b1, 4'hF, 4'hF, 5'd31},  // R4
    {2'b10, 1'b0, 4'hF, 4'h1, 5'd16},  // R4
    {2'b01, 1'b1, 4'h7, 4'h3, 5'd20},  // R5
    {2'b01, 1'b1, 4'h3, 4'h7, 5'd12},  // R5
    {2'b01, 1'b0, 4'h5, 4'h2, 5'd18},  // R5
    {2'b00, 1'b0, 4'h9, 4'h6, 5'd9},   // R6
    {2'b00, 1'b1, 4'hF, 4'h0, 5'd16},  // R6
    {2'b11, 1'b0, 4'h0, 4'h3, 5'd15},  // R7
    {2'b11, 1'b0, 4'h6, 4'h9, 5'd21},  // R7
    {2'b11, 1'b1, 4'hA, 4'h4, 5'd26},  // R7
    {2'b01, 1'b1, 4'h0, 4'h0, 5'd16}   // R5
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [1:0] s, input logic c, input logic [W-1:0] av,
                       input logic [W-1:0] bv);
    @(posedge clk);
    {s1, s0} = s; cin = c; a = av; b = bv; cst = '0;
    @(negedge clk);
  endtask

  function automatic logic [W:0] gold(input logic [1:0] s, input logic c,
                                      input logic [W-1:0] av, input logic [W-1:0] bv);
    logic [W:0] m;
    m = (1 << W) - 1;
    case (s)
      2'b00: gold = av + c;
      2'b01: gold = av + (~{1'b0, bv} & m) + c;
      2'b10: gold = av + bv + c;
      default: gold = av + m + c;
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] seen;
    logic [W-1:0] yexp;
    a = '0; b = '0; s0 = 0; s1 = 0; cin = 0; cst = '0;
    px = 0; py = 0; pz = 0; fc = 0; fp = 0; fq = 0;

    // idle state: all-zero inputs give all-zero outputs (R6, R9)
    drive(2'b00, 1'b0, '0, '0);
    chk("R6 idle result", {cout, f}, 0);
    chk("R9 idle garbage", {fag, cdg}, 0);

    // R10 port counts
    chk("R10 garbage count", $bits(fag) + $bits(cdg), 16);
    chk("R10 constant count", $bits(cst), 4);

    for (int k = 0; k < NV; k++) begin
      drive(VEC[k][15:14], VEC[k][13], VEC[k][12:9], VEC[k][8:5]);
      chk("R4/R5/R6/R7 vector", {cout, f}, VEC[k][4:0]);
    end

    // exhaustive sweep (R3, R8, R9)
    for (int s = 0; s < 4; s++)
      for (int c = 0; c < 2; c++)
        for (int av = 0; av < 16; av++)
          for (int bv = 0; bv < 16; bv++) begin
            drive(s[1:0], c[0], av[W-1:0], bv[W-1:0]);
            chk("R8 sweep", {cout, f}, gold(s[1:0], c[0], av[W-1:0], bv[W-1:0]));
            case (s)
              0: yexp = '0;
              1: yexp = ~bv[W-1:0];
              2: yexp = bv[W-1:0];
              default: yexp = '1;
            endcase
            for (int i = 0; i < W; i++) begin
              chk("R3 addend", fag[2*i+1] ^ a[i], yexp[i]);
              chk("R9 a line", fag[2*i], a[i]);
              chk("R9 b line", cdg[2*i], b[i]);
              chk("R9 swap line", cdg[2*i+1], (b[i] & s0) | (~b[i] & s1));
            end
          end

    // R1 Peres mapping and bijection
    seen = '0;
    for (int v = 0; v < 8; v++) begin
      {px, py, pz} = v[2:0];
      #1;
      chk("R1 peres map", {pp, pq, pr}, {px, px ^ py, (px & py) ^ pz});
      seen[{pp, pq, pr}] = 1'b1;
    end
    chk("R1 peres bijection", seen, 8'hFF);

    // R2 Fredkin mapping, bijection, weight
    seen = '0;
    for (int v = 0; v < 8; v++) begin
      {fc, fp, fq} = v[2:0];
      #1;
      chk("R2 fredkin map", {oc, op, oq},
          {fc, (~fc & fp) | (fc & fq), (fc & fp) | (~fc & fq)});
      chk("R2 fredkin weight", $countones({oc, op, oq}), $countones(v[2:0]));
      seen[{oc, op, oq}] = 1'b1;
    end
    chk("R2 fredkin bijection", seen, 8'hFF);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule